// File: doc/BRIEF.md
# Configuration Frame Error Checker

The checker watches a serial configuration stream that arrives one bit per clock when a qualifier strobe is high. The line idles at 1. A 0 seen while idle begins a frame of fixed length. The checker tests three things in every frame. It checks that each frame is preceded by enough idle 1s. It compares the device code carried in an identification frame with a code fixed at build time. When the identification frame has turned it on, it checks parity separately on the even and the odd bit positions of each frame.

Any detected error sets a sticky flag and moves the controller into a lock-up state that drives an active-low `init_n` output. The lock-up holds until the asynchronous reset or the synchronous program-restart input is asserted. The controller has three states. `ST_IDLE` counts stop bits and waits for a start bit. `ST_BODY` receives the frame bits. `ST_INIT` is the locked error state. The transitions are:
- idle→body on a clean start bit;
- idle→init on a misaligned start bit;
- body→idle when the last frame bit is clean;
- body→init when the last frame bit shows an ID or parity error;
- any state→idle when program is asserted.

Top module: `cfg_frame_checker`

## Requirements
- R1: A frame is DATA_W+4 bits. Position 0 is the start bit (0). Position 1 is the kind bit (1 = identification frame, 0 = data frame). Positions 2..DATA_W+1 are the payload, least significant bit first. Positions DATA_W+2 and DATA_W+3 are parity bits. Zeros inside a frame are not start bits, and cycles with `bit_valid` low change nothing.
- R2: When a 0 arrives in the idle state and fewer than three consecutive valid 1s were received since the last start bit, reset or program, `err_align` is set and the frame is not entered.
- R3: In an identification frame, payload bits [ID_W-1:0] are compared with EXP_ID. On a mismatch, `err_id` is set on the edge that samples the frame's last bit.
- R4: Payload bit ID_W of an identification frame loads the parity-enable bit. The new value applies from the following frame on. Reset and program clear the bit. While it is clear, no parity error is raised.
- R5: While parity is enabled, `err_par` is set at the frame's last bit if either of two checks finds an odd number of ones. One check covers the even positions (0, 2, 4, …). The other covers the odd positions (1, 3, …).
- R6: `init_n` goes low on the same edge that sets any error flag. While it is low, the stream input is ignored.
- R7: Error flags and the low `init_n` are held until reset or program.
- R8: `rst_n` low (asynchronous) or `prog` high (synchronous, overrides the data input) clears all flags, raises `init_n`, clears parity enable and the stop-bit history, and returns to idle.
- R9: When an ID error and a parity error are found at the end of the same frame, both flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog | input | 1 | Synchronous program restart, active high |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial configuration data bit |
| init_n | output | 1 | Low while locked in the error state |
| err_id | output | 1 | Sticky device-code mismatch flag |
| err_align | output | 1 | Sticky frame alignment flag |
| err_par | output | 1 | Sticky parity flag |

## Verification
The properties assume that `rst_n` is asserted at time zero and that `prog` is a clean synchronous level. The stickiness and clearing checks rely only on those two inputs. The stimulus drives every input on the falling edge, keeps `rst_n` low through the first edges, and raises it only away from the active edge. Streams begin with a preamble of 1s, except where a short preamble is the point of the test. Frames are built with computed parity bits that can be corrupted on purpose.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_INIT = 2'd2
    } chk_state_e;

    localparam int FRAME_OVERHEAD = 4;
    localparam int PARITY_LANES   = 2;

endpackage

// File: rtl/cfgchk_stop_hist.sv
module cfgchk_stop_hist #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic push_one,
    input  logic start,
    output logic align_bad
);

    logic [DEPTH-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clr || start) begin
            hist_q <= '0;
        end else if (push_one) begin
            hist_q <= {hist_q[DEPTH-2:0], 1'b1};
        end
    end

    assign align_bad = start && !(&hist_q);

endmodule

// File: rtl/cfgchk_parity.sv
module cfgchk_parity #(
    parameter int LANES = 2,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             acc,
    input  logic [SEL_W-1:0] sel,
    input  logic             bit_in,
    output logic             odd_any
);

    logic [LANES-1:0] fin;

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            logic lane_q;
            logic hit;

            assign hit = acc && (sel == SEL_W'(l));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lane_q <= 1'b0;
                end else if (load) begin
                    lane_q <= (l == 0) ? bit_in : 1'b0;
                end else if (hit) begin
                    lane_q <= lane_q ^ bit_in;
                end
            end

            assign fin[l] = lane_q ^ (hit && bit_in);
        end
    endgenerate

    assign odd_any = |fin;

endmodule

// File: rtl/cfgchk_id_cap.sv
module cfgchk_id_cap #(
    parameter int              ID_W   = 8,
    parameter logic [ID_W-1:0] EXP_ID = 8'hA5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift,
    input  logic bit_in,
    output logic code_ok,
    output logic pen_bit
);

    localparam int CAP_W = ID_W + 1;

    logic [CAP_W-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (shift) begin
            cap_q <= {bit_in, cap_q[CAP_W-1:1]};
        end
    end

    assign code_ok = (cap_q[ID_W-1:0] == EXP_ID);
    assign pen_bit = cap_q[ID_W];

endmodule

// File: rtl/cfg_frame_checker.sv
module cfg_frame_checker
    import cfgchk_pkg::*;
#(
    parameter int              DATA_W   = 16,
    parameter int              ID_W     = 8,
    parameter logic [ID_W-1:0] EXP_ID   = 8'hA5,
    parameter int              STOP_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog,
    input  logic bit_valid,
    input  logic bit_in,
    output logic init_n,
    output logic err_id,
    output logic err_align,
    output logic err_par
);

    localparam int FRAME_LEN = DATA_W + FRAME_OVERHEAD;
    localparam int POS_W     = $clog2(FRAME_LEN + 1);
    localparam int SEL_W     = $clog2(PARITY_LANES);
    localparam logic [POS_W-1:0] P_KIND  = POS_W'(1);
    localparam logic [POS_W-1:0] P_PAYLO = POS_W'(2);
    localparam logic [POS_W-1:0] P_CAPHI = POS_W'(ID_W + 2);
    localparam logic [POS_W-1:0] P_LAST  = POS_W'(FRAME_LEN - 1);

    chk_state_e       state_q, state_d;
    logic [POS_W-1:0] pos_q;
    logic             kind_q, pen_q;
    logic             id_q, al_q, par_q;

    logic take, idle_one, start, body_bit, last, cap_en;
    logic align_bad, par_odd, code_ok, pen_bit;
    logic id_bad, par_bad;

    assign take     = bit_valid && !prog;
    assign idle_one = take && (state_q == ST_IDLE) && bit_in;
    assign start    = take && (state_q == ST_IDLE) && !bit_in;
    assign body_bit = take && (state_q == ST_BODY);
    assign last     = body_bit && (pos_q == P_LAST);
    assign cap_en   = body_bit && (pos_q >= P_PAYLO) && (pos_q <= P_CAPHI);
    assign id_bad   = last && kind_q && !code_ok;
    assign par_bad  = last && pen_q && par_odd;

    cfgchk_stop_hist #(.DEPTH(STOP_MIN)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (prog),
        .push_one  (idle_one),
        .start     (start),
        .align_bad (align_bad)
    );

    cfgchk_parity #(.LANES(PARITY_LANES), .SEL_W(SEL_W)) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .acc     (body_bit),
        .sel     (pos_q[SEL_W-1:0]),
        .bit_in  (bit_in),
        .odd_any (par_odd)
    );

    cfgchk_id_cap #(.ID_W(ID_W), .EXP_ID(EXP_ID)) u_id (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (cap_en),
        .bit_in  (bit_in),
        .code_ok (code_ok),
        .pen_bit (pen_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (prog) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start)  state_d = align_bad ? ST_INIT : ST_BODY;
                ST_BODY: if (last)   state_d = (id_bad || par_bad) ? ST_INIT : ST_IDLE;
                ST_INIT: state_d = ST_INIT;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // frame datapath and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            kind_q <= 1'b0;
            pen_q  <= 1'b0;
            id_q   <= 1'b0;
            al_q   <= 1'b0;
            par_q  <= 1'b0;
        end else if (prog) begin
            pos_q  <= '0;
            kind_q <= 1'b0;
            pen_q  <= 1'b0;
            id_q   <= 1'b0;
            al_q   <= 1'b0;
            par_q  <= 1'b0;
        end else begin
            if (start) begin
                pos_q <= POS_W'(1);
            end else if (body_bit) begin
                pos_q <= pos_q + POS_W'(1);
            end
            if (body_bit && (pos_q == P_KIND)) begin
                kind_q <= bit_in;
            end
            if (last && kind_q) begin
                pen_q <= pen_bit;
            end
            if (align_bad) al_q  <= 1'b1;
            if (id_bad)    id_q  <= 1'b1;
            if (par_bad)   par_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        init_n    = (state_q != ST_INIT);
        err_id    = id_q;
        err_align = al_q;
        err_par   = par_q;
    end

endmodule

// File: rtl/cfgchk_props.sv
module cfgchk_props (
    input logic clk,
    input logic rst_n,
    input logic prog,
    input logic bit_valid,
    input logic init_n,
    input logic err_id,
    input logic err_align,
    input logic err_par
);

    a_r7_id_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_id && !prog |=> err_id);

    a_r7_align_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_align && !prog |=> err_align);

    a_r7_par_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_par && !prog |=> err_par);

    a_r6_init_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n && !prog |=> !init_n);

    a_r6_init_matches_flags: assert property (@(posedge clk) disable iff (!rst_n)
        init_n == !(err_id || err_align || err_par));

    a_r8_prog_clears: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> init_n && !err_id && !err_align && !err_par);

    a_r1_idle_cycle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid && !prog |=> $stable({init_n, err_id, err_align, err_par}));

endmodule

bind cfg_frame_checker cfgchk_props u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog      (prog),
    .bit_valid (bit_valid),
    .init_n    (init_n),
    .err_id    (err_id),
    .err_align (err_align),
    .err_par   (err_par)
);

// File: tb/test_cfg_frame_checker.sv
module test_cfg_frame_checker;

    localparam int CLK_P  = 10;
    localparam int DATA_W = 16;
    localparam int ID_W   = 8;
    localparam logic [ID_W-1:0] EXP = 8'hA5;
    localparam int FLEN   = DATA_W + 4;

    logic clk = 1'b0;
    logic rst_n, prog, bit_valid, bit_in;
    logic init_n, err_id, err_align, err_par;

    int nchk = 0;
    int nerr = 0;

    // reference model state
    int m_mode;   // 0 idle, 1 body, 2 init
    int m_run;
    bit m_q[$];
    bit m_pen, m_id, m_al, m_par;

    always #(CLK_P/2) clk = ~clk;

    cfg_frame_checker #(.DATA_W(DATA_W), .ID_W(ID_W), .EXP_ID(EXP), .STOP_MIN(3)) i_cfg_frame_checker (
        .clk(clk), .rst_n(rst_n), .prog(prog), .bit_valid(bit_valid), .bit_in(bit_in),
        .init_n(init_n), .err_id(err_id), .err_align(err_align), .err_par(err_par)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_mode = 0; m_run = 0; m_q.delete();
        m_pen = 0; m_id = 0; m_al = 0; m_par = 0;
    endtask

    task automatic model_step(input bit v, input bit b, input bit p);
        if (p) begin
            model_clear();
            return;
        end
        if (!v || m_mode == 2) return;
        if (m_mode == 0) begin
            if (b) m_run++;
            else begin
                if (m_run < 3) begin m_al = 1; m_mode = 2; end
                else begin m_q.delete(); m_q.push_back(1'b0); m_mode = 1; end
                m_run = 0;
            end
        end else begin
            m_q.push_back(b);
            if (m_q.size() == FLEN) begin
                bit ev = 0, od = 0, idb = 0, pb = 0;
                bit [ID_W-1:0] code = '0;
                for (int i = 0; i < FLEN; i++) begin
                    if (i % 2 == 0) ev ^= m_q[i]; else od ^= m_q[i];
                end
                if (m_pen && (ev || od)) pb = 1;
                if (m_q[1]) begin
                    for (int k = 0; k < ID_W; k++) code[k] = m_q[2 + k];
                    if (code != EXP) idb = 1;
                    m_pen = m_q[2 + ID_W];
                end
                if (idb) m_id = 1;
                if (pb) m_par = 1;
                m_mode = (idb || pb) ? 2 : 0;
                m_run = 0;
            end
        end
    endtask

    task automatic compare();
        check("R3 err_id", err_id, m_id);
        check("R2 err_align", err_align, m_al);
        check("R5 err_par", err_par, m_par);
        check("R6 init_n", init_n, (m_mode != 2));
    endtask

    task automatic drive(input bit v, input bit b, input bit p);
        @(negedge clk);
        bit_valid = v; bit_in = b; prog = p;
        model_step(v, b, p);
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) drive(1, 1, 0);
    endtask

    task automatic do_prog();
        drive(1, 0, 1);
    endtask

    task automatic send_frame(input bit kind, input logic [DATA_W-1:0] pay,
                              input bit fe, input bit fo, input bit gap);
        bit fq[$];
        bit lane[2];
        fq.push_back(1'b0);
        fq.push_back(kind);
        for (int k = 0; k < DATA_W; k++) fq.push_back(pay[k]);
        lane[0] = 0; lane[1] = 0;
        for (int i = 0; i < fq.size(); i++) lane[i % 2] ^= fq[i];
        for (int i = DATA_W + 2; i < FLEN; i++)
            fq.push_back(lane[i % 2] ^ ((i % 2 == 0) ? fe : fo));
        for (int i = 0; i < FLEN; i++) begin
            if (gap && i == 3) begin
                drive(0, 0, 0);
                drive(0, 1, 0);
            end
            drive(1, fq[i], 0);
        end
    endtask

    function automatic logic [DATA_W-1:0] id_pay(input logic [ID_W-1:0] code, input bit pen);
        logic [DATA_W-1:0] r = '0;
        r[ID_W-1:0] = code;
        r[ID_W] = pen;
        r[DATA_W-1] = 1'b1;
        return r;
    endfunction

    bit done = 0;

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; prog = 1'b0; bit_valid = 1'b0; bit_in = 1'b1;
        model_clear();
        repeat (2) @(posedge clk);
        #1;
        check("R8 reset init_n", init_n, 1'b1);
        check("R8 reset flags", err_id | err_align | err_par, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R3 good ID, R4 parity disabled ignores bad parity
        ones(4);
        send_frame(1, id_pay(EXP, 0), 0, 0, 0);
        check("R3 matching code no error", err_id, 1'b0);
        ones(3);
        send_frame(0, 16'h1234, 1, 0, 0);
        check("R4 parity off ignores bad parity", err_par, 1'b0);

        // R1 zeros inside body and invalid cycles, R5 good parity
        ones(3);
        send_frame(1, id_pay(EXP, 1), 0, 0, 0);
        ones(3);
        send_frame(0, 16'h0F30, 0, 0, 1);
        check("R1 body zeros and gaps no error", init_n, 1'b1);
        ones(5);
        send_frame(0, 16'h8001, 1, 0, 0);
        check("R5 even lane error", err_par, 1'b1);
        check("R6 init low after error", init_n, 1'b0);
        ones(1);
        send_frame(0, 16'h0000, 0, 1, 0);
        check("R7 flag held while locked", err_par, 1'b1);
        check("R6 input ignored in init", err_align, 1'b0);

        // R8 program clears; R2 short preamble
        do_prog();
        check("R8 prog clears flags", err_par, 1'b0);
        check("R8 prog raises init_n", init_n, 1'b1);
        ones(2);
        drive(1, 0, 0);
        check("R2 short preamble alignment error", err_align, 1'b1);

        // R3 mismatched code
        do_prog();
        ones(3);
        send_frame(1, id_pay(8'h5A, 0), 0, 0, 0);
        check("R3 mismatch flagged", err_id, 1'b1);
        check("R3 no parity flag", err_par, 1'b0);

        // R5 odd lane
        do_prog();
        ones(3);
        send_frame(1, id_pay(EXP, 1), 0, 0, 0);
        ones(3);
        send_frame(0, 16'hBEEF, 0, 1, 0);
        check("R5 odd lane error", err_par, 1'b1);

        // R9 both errors in one frame
        do_prog();
        ones(3);
        send_frame(1, id_pay(EXP, 1), 0, 0, 0);
        ones(3);
        send_frame(1, id_pay(8'h00, 1), 1, 0, 0);
        check("R9 id flag", err_id, 1'b1);
        check("R9 parity flag", err_par, 1'b1);

        // R2 frame followed too soon by a zero
        do_prog();
        ones(3);
        send_frame(1, id_pay(EXP, 0), 0, 0, 0);
        ones(1);
        drive(1, 0, 0);
        check("R2 misaligned start after frame", err_align, 1'b1);

        // R8 asynchronous reset mid-frame
        do_prog();
        ones(3);
        drive(1, 0, 0); drive(1, 1, 0); drive(1, 0, 0);
        @(negedge clk);
        bit_valid = 1'b0; prog = 1'b0; rst_n = 1'b0;
        model_clear();
        #1;
        compare();
        @(negedge clk); rst_n = 1'b1;
        ones(3);
        send_frame(1, id_pay(EXP, 0), 0, 0, 0);
        check("R8 clean after async reset", init_n, 1'b1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule